// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets an 8-bit processor core reach asynchronous external SRAM over a pin-saving multiplexed bus. One 8-bit group of lines carries the low address byte at the start of each access and the data byte afterwards. The high address byte has dedicated lines. A latch-enable strobe tells an external transparent latch when to capture the low address byte. Separate active-low read and write strobes mark the data phase. All timing comes from the internal system clock, and no clock is sent to the memory.

The core issues one single-byte read or write at a time. A request is taken only when the controller is idle. The busy flag stays high from acceptance until a one-cycle done pulse, which also carries the byte that was read. Configuration inputs set an upper-address sector boundary and a wait setting for each of the two sectors, so that two memories with different access times can share the bus. A further configuration input enables a bus-keeper, which holds the last value on the shared lines while the controller is not driving them. The shared lines are presented as separate output, output-enable and input signals, plus a keeper-active flag for the pad.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset, busy, done and ale are 0, rd_n and wr_n are 1, and ad_oe is 0.
- R2: A request with req_valid high is accepted only when busy is 0. A request presented while busy is 1 is ignored: no second latch-enable pulse follows, and busy is 0 in the cycle after the done pulse.
- R3: In the first cycle after acceptance, ale is 1, ad_oe is 1, ad_out carries address bits [7:0] and a_hi carries address bits [15:8]. In the second cycle, ale is 0 and the low address byte is still driven.
- R4: The wait setting ws (2 bits) sets the number of cycles the active strobe stays low: 0 gives 1, 1 gives 2, 2 gives 3 and 3 gives 3.
- R5: With ws = 3, one extra cycle follows the strobe release, with both strobes high and a_hi unchanged, before done is raised.
- R6: If address bits [15:8] are below cfg_bound (unsigned), the access uses cfg_ws_lo. Otherwise it uses cfg_ws_hi, so cfg_bound = 0 puts every address in the upper sector.
- R7: During a read, ad_oe is 0 whenever rd_n is 0. ad_in is sampled in the last cycle of the read strobe, and rdata shows that byte in the done cycle.
- R8: During a write, ad_oe is 1 and ad_out equals the write data while wr_n is 0, and rd_n stays 1.
- R9: done is high for exactly one cycle. For strobe length n and extra cycle h (R4, R5), done appears 3+n+h cycles after acceptance. busy is high from the first cycle after acceptance through the done cycle and is 0 in the next cycle.
- R10: While ad_oe is 0 and cfg_keep_en is 1, ad_keep is 1 and ad_out holds the last byte on the shared lines, which is either the last byte driven or the last read byte captured. While cfg_keep_en is 0, ad_keep is 0.
- R11: rd_n and wr_n are never low together, and ale is never high while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| cfg_bound | input | 8 | Sector boundary on address bits [15:8] |
| cfg_ws_lo | input | 2 | Wait setting for the lower sector |
| cfg_ws_hi | input | 2 | Wait setting for the upper sector |
| cfg_keep_en | input | 1 | Bus-keeper enable |
| ad_out | output | 8 | Shared address/data lines, output value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, sampled value |
| ad_keep | output | 1 | Keeper active (weakly hold ad_out) |
| a_hi | output | 8 | High address byte lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The checker assumes that configuration inputs are stable while an access is in flight. It also assumes that ad_in holds the memory byte for the whole read strobe, since no protocol property can tolerate a memory that changes data mid-strobe. The bench changes cfg_ws_lo, cfg_ws_hi, cfg_bound and cfg_keep_en only between accesses. It sets ad_in to a value computed from the address before each request. A late request made during the latch cycle tests that overlapping requests are ignored.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int WS_W  = 2;
    localparam int CNT_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_LATCH,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] strobe_cycles;
        logic             hold;
    } timing_t;

    // Wait setting to strobe length and trailing address-hold cycle.
    function automatic timing_t decode_wait(input logic [WS_W-1:0] ws);
        timing_t t;
        case (ws)
            2'd0:    begin t.strobe_cycles = 2'd1; t.hold = 1'b0; end
            2'd1:    begin t.strobe_cycles = 2'd2; t.hold = 1'b0; end
            2'd2:    begin t.strobe_cycles = 2'd3; t.hold = 1'b0; end
            default: begin t.strobe_cycles = 2'd3; t.hold = 1'b1; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mxbus_sector_sel.sv
module mxbus_sector_sel
    import mxbus_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] bound,
    input  logic [WS_W-1:0] ws_lo,
    input  logic [WS_W-1:0] ws_hi,
    output timing_t         tim
);
    logic in_lower;

    always_comb begin
        in_lower = (addr_hi < bound);
        tim      = decode_wait(in_lower ? ws_lo : ws_hi);
    end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  timing_t           tim_in,
    output phase_e            phase,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              lat_write,
    output logic              sample_now
);
    timing_t          lat_tim;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_tim   <= '0;
            cnt       <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        lat_write <= req_write;
                        lat_tim   <= tim_in;
                        phase     <= PH_ADDR;
                    end
                end
                PH_ADDR:  phase <= PH_LATCH;
                PH_LATCH: begin
                    cnt   <= lat_tim.strobe_cycles - 2'd1;
                    phase <= PH_STROBE;
                end
                PH_STROBE: begin
                    if (cnt == '0) phase <= lat_tim.hold ? PH_HOLD : PH_DONE;
                    else           cnt   <= cnt - 2'd1;
                end
                PH_HOLD:  phase <= PH_DONE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign sample_now = (phase == PH_STROBE) && (cnt == '0) && !lat_write;
endmodule

// File: rtl/mxbus_pins.sv
module mxbus_pins
    import mxbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              is_write,
    input  logic              sample_now,
    input  logic              keep_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ad_keep,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done
);
    logic [DATA_W-1:0] last_val;
    logic [DATA_W-1:0] drive_val;
    logic              addr_phase;
    logic              data_phase;

    always_comb begin
        addr_phase = (phase == PH_ADDR) || (phase == PH_LATCH);
        data_phase = (phase == PH_STROBE) || (phase == PH_HOLD) || (phase == PH_DONE);
        drive_val  = addr_phase ? addr_lo : wdata;
        ad_oe      = addr_phase || (is_write && data_phase);
        ad_out     = ad_oe ? drive_val : last_val;
        ad_keep    = keep_en && !ad_oe;
        ale        = (phase == PH_ADDR);
        rd_n       = !((phase == PH_STROBE) && !is_write);
        wr_n       = !((phase == PH_STROBE) && is_write);
        done       = (phase == PH_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_val <= '0;
            rdata    <= '0;
        end else begin
            if (ad_oe)           last_val <= drive_val;
            else if (sample_now) last_val <= ad_in;
            if (sample_now)      rdata    <= ad_in;
        end
    end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    input  logic [ADDR_W-DATA_W-1:0] cfg_bound,
    input  logic [WS_W-1:0]          cfg_ws_lo,
    input  logic [WS_W-1:0]          cfg_ws_hi,
    input  logic                     cfg_keep_en,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ad_keep,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    timing_t           tim;
    phase_e            phase;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_write;
    logic              sample_now;

    mxbus_sector_sel #(.HI_W(HI_W)) u_sector (
        .addr_hi (req_addr[ADDR_W-1:DATA_W]),
        .bound   (cfg_bound),
        .ws_lo   (cfg_ws_lo),
        .ws_hi   (cfg_ws_hi),
        .tim     (tim)
    );

    mxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .tim_in     (tim),
        .phase      (phase),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .lat_write  (lat_write),
        .sample_now (sample_now)
    );

    mxbus_pins #(.DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .addr_lo    (lat_addr[DATA_W-1:0]),
        .wdata      (lat_wdata),
        .is_write   (lat_write),
        .sample_now (sample_now),
        .keep_en    (cfg_keep_en),
        .ad_in      (ad_in),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ad_keep    (ad_keep),
        .rdata      (rdata),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .done       (done)
    );

    assign busy = (phase != PH_IDLE);
    assign a_hi = lat_addr[ADDR_W-1:DATA_W];
endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic ad_keep,
    input logic cfg_keep_en
);
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));

    a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    a_r2_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> (busy && ale));

    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && !ale));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    a_r8_write_driven: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    a_r10_keeper_on: assert property (@(posedge clk) disable iff (rst)
        (!ad_oe && cfg_keep_en) |-> ad_keep);

    a_r10_keeper_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_keep_en |-> !ad_keep);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && wr_n && !ale && !done));
endmodule

bind mxbus_ctrl mxbus_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ad_oe       (ad_oe),
    .ad_keep     (ad_keep),
    .cfg_keep_en (cfg_keep_en)
);

// File: tb/tb_mxbus_ctrl.sv
`timescale 1ns/100ps
module tb_mxbus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, ad_oe, ad_keep, ale, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, a_hi;
    logic [7:0]  cfg_bound = '0;
    logic [1:0]  cfg_ws_lo = '0;
    logic [1:0]  cfg_ws_hi = '0;
    logic        cfg_keep_en = 1'b0;
    logic [7:0]  ad_in = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mxbus_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .cfg_bound(cfg_bound), .cfg_ws_lo(cfg_ws_lo),
        .cfg_ws_hi(cfg_ws_hi), .cfg_keep_en(cfg_keep_en), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ad_keep(ad_keep), .a_hi(a_hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic access(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                          input logic keep, input logic probe);
        int ws, n, h, dcyc, scnt;
        logic [7:0] mv;
        mv = mem_val(addr);
        ws = (addr[15:8] < cfg_bound) ? int'(cfg_ws_lo) : int'(cfg_ws_hi);   // R6
        n  = (ws == 0) ? 1 : (ws == 1) ? 2 : 3;                                // R4
        h  = (ws == 3) ? 1 : 0;                                                // R5
        dcyc = 3 + n + h;
        scnt = 0;
        cfg_keep_en = keep;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; ad_in = mv;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= 12; c++) begin
            if (c == 1) begin
                chk(ale && ad_oe && busy, "R3 ale/oe/busy", {ale, ad_oe, busy}, 7);
                chk(ad_out == addr[7:0], "R3 low addr", ad_out, addr[7:0]);
                chk(a_hi == addr[15:8], "R3 high addr", a_hi, addr[15:8]);
            end
            if (c == 2) begin
                chk(!ale && ad_oe && ad_out == addr[7:0], "R3 latch hold", {ale, ad_oe}, 1);
            end
            if (wr ? !wr_n : !rd_n) begin
                scnt++;
                if (wr) chk(ad_oe && ad_out == wd && rd_n, "R8 write drive", ad_out, wd);
                else    chk(!ad_oe, "R7 read released", ad_oe, 0);
            end
            chk(!(!rd_n && !wr_n), "R11 strobe exclusive", {rd_n, wr_n}, 3);
            if (c == dcyc) begin
                chk(done && busy, "R9 done in cycle", c, dcyc);
                chk(scnt == n, "R4 R6 strobe length", scnt, n);
                if (h == 1) chk(a_hi == addr[15:8] && rd_n && wr_n, "R5 hold addr", a_hi, addr[15:8]);
                if (!wr) chk(rdata == mv, "R7 read data", rdata, mv);
            end else if (c < dcyc) begin
                chk(!done && busy, "R9 busy before done", {done, busy}, 1);
            end
            if (c == dcyc + 1) begin
                chk(!busy && !done && !ale, "R9 R2 idle after done", {busy, done, ale}, 0);
                chk(!ad_oe && ad_keep == keep, "R10 keeper flag", ad_keep, keep);
                if (keep) chk(ad_out == (wr ? wd : mv), "R10 kept value", ad_out, wr ? wd : mv);
                break;
            end
            if (probe && c == 2) begin
                req_valid = 1'b1; req_addr = addr ^ 16'h0101; req_write = !wr;
            end
            if (probe && c == 3) req_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  bounds [3];
        logic [15:0] addrs  [3];
        bounds[0] = 8'h00; bounds[1] = 8'h40; bounds[2] = 8'hFF;
        addrs[0]  = 16'h3F12; addrs[1] = 16'h4034; addrs[2] = 16'hFF77;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe, "R1 reset state",
            {busy, done, ale, rd_n, wr_n, ad_oe}, 6'b000110);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !ad_oe && !ad_keep, "R1 after release", {busy, ad_oe, ad_keep}, 0);
        for (int wl = 0; wl < 4; wl++)
            for (int wh = 0; wh < 4; wh++)
                for (int b = 0; b < 3; b++)
                    for (int a = 0; a < 3; a++)
                        for (int w = 0; w < 2; w++) begin
                            cfg_ws_lo = 2'(wl);
                            cfg_ws_hi = 2'(wh);
                            cfg_bound = bounds[b];
                            access(w[0], addrs[a], 8'(wl * 37 + wh * 11 + a * 5 + w + 3),
                                   1'((wl + wh + a) % 2), wl == wh);
                        end
        // R10: keeper disabled while idle after a write
        cfg_keep_en = 1'b0;
        @(negedge clk);
        chk(!ad_keep && !ad_oe, "R10 keeper disabled", ad_keep, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule